// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers a parameterised set of external interrupt inputs and delivers them to several hart contexts. A context is one privilege mode of one hardware thread. Every source reaches every context. Each context has its own interrupt line, its own enable mask and its own priority threshold. Each source passes through a gateway, which turns a level or edge input into a single pending bit. The gateway also keeps the source quiet while a handler owns it.

Software reaches the block over a simple word-addressed register bus. A context reads its claim word to take the best eligible source and to learn its ID. After servicing the source, the context writes that ID back to the same word to complete it. Source ID 0 means "no interrupt", so the block numbers sources from 1 up to the source count. A context slot marked absent at build time stays silent.

Top module: `plic_top`

## Requirements
- R1: After reset every interrupt line is low, and the priority, pending, enable, threshold and claim words all read zero.
- R2: Word address map: priority of source k at 0x00+k, holding PRIO_W bits, with upper bits reading zero. Pending word at 0x20, where bit k is source k. Enable word of context c at 0x40+c, where bit k is source k. Threshold of context c at 0x60+2c. Claim/complete word of context c at 0x61+2c. Read data appears on rsp_rdata_o with rsp_valid_o one cycle after the request, and only then.
- R3: Context c's interrupt line is high exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. Priority 0 is therefore never delivered.
- R4: A claim read returns the eligible source with the highest priority. On a tie it returns the lowest ID. It returns 0 when no source is eligible.
- R5: A claim read clears that source's pending bit. The source does not become pending again until its ID is written to a claim/complete word.
- R6: For a level source, a complete re-asserts pending at once if the input is still high, and leaves it clear if the input is low.
- R7: For an edge source, a rising edge sets pending. Rising edges that arrive while the source is claimed are counted, up to 2^CNT_W-1. Each later complete then re-arms pending once per counted edge.
- R8: An absent context never raises its line, and its claim read returns 0.
- R9: Enables act per context: a source enabled only for one context raises no other context's line.
- R10: Writes to the pending word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt inputs, bit k-1 is source k |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a request |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
Directed sequences build the cases that random stimulus rarely reaches:
- a priority equal to the threshold;
- two sources tying on priority;
- a level input still high or already low at complete time;
- edge pulses arriving while their source is claimed;
- an absent context with every source enabled.

Random rounds then draw level inputs, priorities, per-context enables and thresholds. After each round the bench compares every interrupt line and a claim on a random context against a bench-side arbitration function. These rounds tell apart mistakes in the strict greater-than comparison, in tie ordering, in per-context mask selection and in pending bookkeeping across claims.

// File: rtl/plic_pkg.sv
package plic_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Upper three address bits select a register region.
    typedef enum logic [2:0] {
        RG_PRIO = 3'd0,
        RG_PEND = 3'd1,
        RG_EN   = 3'd2,
        RG_CTX  = 3'd3
    } region_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter bit EDGE  = 1'b0,
    parameter int CNT_W = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic claim_i,
    input  logic cmpl_i,
    output logic pend_o
);
    typedef struct packed {
        logic             pend;
        logic             busy;
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } gw_t;

    gw_t g_d, g_q;
    logic rise;

    always_comb begin
        g_d  = g_q;
        rise = src_i & ~g_q.prev;
        g_d.prev = src_i;
        if (claim_i) begin
            g_d.pend = 1'b0;
            g_d.busy = 1'b1;
        end else if (cmpl_i && g_q.busy) begin
            g_d.busy = 1'b0;
        end
        if (EDGE) begin
            if (g_d.busy || g_d.pend) begin
                // edges seen while claimed are remembered; while merely pending they merge
                if (rise && g_d.busy && (g_d.cnt != {CNT_W{1'b1}}))
                    g_d.cnt = g_d.cnt + 1'b1;
            end else if (rise) begin
                g_d.pend = 1'b1;
            end else if (g_d.cnt != '0) begin
                g_d.pend = 1'b1;
                g_d.cnt  = g_d.cnt - 1'b1;
            end
        end else begin
            if (!g_d.busy && !g_d.pend && src_i)
                g_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign pend_o = g_q.pend;
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NUM_SRC = 10,
    parameter int PRIO_W  = 3,
    parameter bit PRESENT = 1'b1,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]             pend_i,
    input  logic [NUM_SRC:1]             en_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              id_o,
    output logic                         irq_o
);
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;
    logic              found;

    always_comb begin
        best_p  = '0;
        best_id = '0;
        found   = 1'b0;
        // ascending scan with strict compare keeps the lowest ID on ties
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (pend_i[k] && en_i[k] && (prio_i[k] > thr_i) &&
                (!found || (prio_i[k] > best_p))) begin
                best_p  = prio_i[k];
                best_id = ID_W'(k);
                found   = 1'b1;
            end
        end
        irq_o = PRESENT & found;
        id_o  = PRESENT ? best_id : '0;
    end
endmodule

// File: rtl/plic_top.sv
module plic_top #(
    parameter int                 NUM_SRC     = 10,
    parameter int                 NUM_CTX     = 4,
    parameter int                 PRIO_W      = 3,
    parameter int                 CNT_W       = 2,
    parameter logic [NUM_SRC:1]   EDGE_MASK   = 10'b11_0000_0000,
    parameter logic [NUM_CTX-1:0] CTX_PRESENT = 4'b0111
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_SRC:1]            src_i,
    input  logic                        bus_req_i,
    input  logic                        bus_we_i,
    input  logic [plic_pkg::ADDR_W-1:0] bus_addr_i,
    input  logic [plic_pkg::DATA_W-1:0] bus_wdata_i,
    output logic                        rsp_valid_o,
    output logic [plic_pkg::DATA_W-1:0] rsp_rdata_o,
    output logic [NUM_CTX-1:0]          irq_o
);
    import plic_pkg::*;

    localparam int ID_W = $clog2(NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC:1][PRIO_W-1:0]  prio;
        logic [NUM_CTX-1:0][NUM_SRC:1] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
        logic                          rvalid;
        logic [DATA_W-1:0]             rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic [NUM_SRC:1]            pend_w;
    logic [NUM_SRC:1]            claim_d, cmpl_d;
    logic [NUM_CTX-1:0][ID_W-1:0] best_w;
    logic [4:0]                  idx;

    // per-source gateways
    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
        plic_gateway #(
            .EDGE  (EDGE_MASK[k]),
            .CNT_W (CNT_W)
        ) u_gw (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .src_i   (src_i[k]),
            .claim_i (claim_d[k]),
            .cmpl_i  (cmpl_d[k]),
            .pend_o  (pend_w[k])
        );
    end

    // per-context arbitration
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        plic_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .PRESENT (CTX_PRESENT[c])
        ) u_arb (
            .pend_i (pend_w),
            .en_i   (s_q.en[c]),
            .prio_i (s_q.prio),
            .thr_i  (s_q.thr[c]),
            .id_o   (best_w[c]),
            .irq_o  (irq_o[c])
        );
    end

    assign idx = bus_addr_i[4:0];

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = bus_req_i;
        s_d.rdata  = '0;
        claim_d    = '0;
        cmpl_d     = '0;
        if (bus_req_i) begin
            case (region_e'(bus_addr_i[7:5]))
                RG_PRIO: begin
                    for (int k = 1; k <= NUM_SRC; k++) begin
                        if (idx == 5'(k)) begin
                            if (bus_we_i) s_d.prio[k] = bus_wdata_i[PRIO_W-1:0];
                            else          s_d.rdata   = DATA_W'(s_q.prio[k]);
                        end
                    end
                end
                RG_PEND: begin
                    if (!bus_we_i && idx == 5'd0)
                        s_d.rdata = DATA_W'({pend_w, 1'b0});
                end
                RG_EN: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (idx == 5'(c)) begin
                            if (bus_we_i) s_d.en[c] = bus_wdata_i[NUM_SRC:1];
                            else          s_d.rdata = DATA_W'({s_q.en[c], 1'b0});
                        end
                    end
                end
                RG_CTX: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (idx[4:1] == 4'(c)) begin
                            if (!idx[0]) begin
                                if (bus_we_i) s_d.thr[c] = bus_wdata_i[PRIO_W-1:0];
                                else          s_d.rdata  = DATA_W'(s_q.thr[c]);
                            end else if (bus_we_i) begin
                                for (int k = 1; k <= NUM_SRC; k++)
                                    if (bus_wdata_i == DATA_W'(k)) cmpl_d[k] = 1'b1;
                            end else begin
                                s_d.rdata = DATA_W'(best_w[c]);
                                for (int k = 1; k <= NUM_SRC; k++)
                                    if (best_w[c] == ID_W'(k)) claim_d[k] = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rsp_valid_o = s_q.rvalid;
    assign rsp_rdata_o = s_q.rdata;
endmodule

// File: rtl/plic_checker.sv
module plic_checker #(
    parameter int                 NUM_SRC     = 10,
    parameter int                 NUM_CTX     = 4,
    parameter int                 PRIO_W      = 3,
    parameter logic [NUM_CTX-1:0] CTX_PRESENT = 4'b0111
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          bus_req_i,
    input logic                          bus_we_i,
    input logic [7:0]                    bus_addr_i,
    input logic                          rsp_valid_o,
    input logic [31:0]                   rsp_rdata_o,
    input logic [NUM_CTX-1:0]            irq_o,
    input logic [NUM_SRC:1]              pend,
    input logic [NUM_CTX-1:0][PRIO_W-1:0] thr
);
    logic              claim_rd;
    logic [NUM_SRC:0]  pend_ext;
    logic              id_still_pending;

    assign claim_rd = bus_req_i && !bus_we_i && (bus_addr_i[7:5] == 3'd3) && bus_addr_i[0];
    assign pend_ext = {pend, 1'b0};
    always_comb begin
        id_still_pending = 1'b0;
        for (int k = 1; k <= NUM_SRC; k++)
            if (rsp_rdata_o == 32'(k) && pend_ext[k]) id_still_pending = 1'b1;
    end

    AST_ABSENT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o & ~CTX_PRESENT) == '0); // R8

    AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_i |=> rsp_valid_o); // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_req_i |=> !rsp_valid_o); // R2

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> (|pend)); // R3

    AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_rd |=> !id_still_pending); // R5

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr
        AST_THR_MAX_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (thr[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]); // R3
    end
endmodule

bind plic_top plic_checker #(
    .NUM_SRC     (NUM_SRC),
    .NUM_CTX     (NUM_CTX),
    .PRIO_W      (PRIO_W),
    .CTX_PRESENT (CTX_PRESENT)
) u_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_o       (irq_o),
    .pend        (pend_w),
    .thr         (s_q.thr)
);

// File: tb/plic_top_tb.sv
module plic_top_tb;
    localparam int NS = 10;
    localparam int NC = 4;
    localparam int PW = 3;
    localparam logic [NC-1:0] PRES = 4'b0111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS:1]   src = '0;
    logic          req = 1'b0, we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int errors = 0;

    logic [NS:1][PW-1:0]  prio_m;
    logic [NC-1:0][NS:1]  en_m;
    logic [NC-1:0][PW-1:0] thr_m;
    logic [NS:1]          pend_m;

    always #4 clk = ~clk;

    plic_top #(
        .NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW), .CNT_W(2),
        .EDGE_MASK(10'b11_0000_0000), .CTX_PRESENT(PRES)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); d = rsp_rdata; req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int k);
        @(negedge clk); src[k] = 1'b1;
        @(negedge clk); src[k] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; src = '0;
        idle(2); rst_n = 1'b1; idle(1);
    endtask

    function automatic int best(input int c);
        int id = 0;
        logic [PW-1:0] bp = '0;
        if (!PRES[c]) return 0;
        for (int k = 1; k <= NS; k++)
            if (pend_m[k] && en_m[c][k] && prio_m[k] > thr_m[c] && (id == 0 || prio_m[k] > bp)) begin
                id = k; bp = prio_m[k];
            end
        return id;
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd2024));
        idle(2); rst_n = 1'b1; idle(1);

        // R1 reset state
        chk(irq == '0, "R1 irq", 32'(irq), 0);
        rd(8'h03, d); chk(d == 0, "R1 prio", d, 0);
        rd(8'h20, d); chk(d == 0, "R1 pend", d, 0);
        rd(8'h61, d); chk(d == 0, "R4 empty claim", d, 0);

        // R2 register access and width
        wr(8'h03, 5); rd(8'h03, d); chk(d == 5, "R2 prio rw", d, 5);
        wr(8'h03, 32'hFF); rd(8'h03, d); chk(d == 7, "R2 prio width", d, 7);
        wr(8'h03, 5);

        // pending and read-only pending word
        src[3] = 1'b1; idle(2);
        rd(8'h20, d); chk(d == 32'h8, "R2 pend bit", d, 32'h8);
        wr(8'h20, 0); rd(8'h20, d); chk(d == 32'h8, "R10 pend ro", d, 32'h8);

        // R3 threshold, R9 per-context enable
        chk(irq[0] == 1'b0, "R3 disabled", 32'(irq), 0);
        wr(8'h40, 32'h8); wr(8'h60, 5); idle(1);
        chk(irq[0] == 1'b0, "R3 equal thr", 32'(irq), 0);
        wr(8'h60, 4); idle(1);
        chk(irq[0] == 1'b1, "R3 above thr", 32'(irq), 1);
        chk(irq[1] == 1'b0, "R9 other ctx", 32'(irq), 0);
        wr(8'h03, 0); idle(1);
        chk(irq[0] == 1'b0, "R3 prio zero", 32'(irq), 0);
        wr(8'h03, 5);

        // R4 tie and ordering, R5 ownership, R6 level rearm
        wr(8'h02, 5); src[2] = 1'b1; wr(8'h40, 32'hC); idle(2);
        rd(8'h61, d); chk(d == 2, "R4 tie lowest id", d, 2);
        idle(3);
        rd(8'h20, d); chk(d[2] == 1'b0, "R5 held after claim", d, 0);
        rd(8'h61, d); chk(d == 3, "R4 next", d, 3);
        rd(8'h61, d); chk(d == 0, "R4 none left", d, 0);
        wr(8'h61, 2); rd(8'h20, d); chk(d[3:2] == 2'b01, "R6 rearm high", d, 32'h4);
        src[3] = 1'b0; wr(8'h61, 3); rd(8'h20, d); chk(d[3] == 1'b0, "R6 low no rearm", d, 0);
        wr(8'h04, 6); src[4] = 1'b1; wr(8'h40, 32'h1C); idle(1);
        rd(8'h61, d); chk(d == 4, "R4 higher prio", d, 4);
        src[4] = 1'b0; wr(8'h61, 4);
        src[2] = 1'b0; rd(8'h61, d); wr(8'h61, d);
        rd(8'h20, d); chk(d == 0, "R5 drained", d, 0);

        // R7 edge source with counted edges
        wr(8'h09, 1); wr(8'h41, 32'h200); wr(8'h62, 0);
        pulse(9);
        rd(8'h20, d); chk(d == 32'h200, "R7 edge pend", d, 32'h200);
        chk(irq[1] == 1'b1, "R7 irq", 32'(irq), 2);
        rd(8'h63, d); chk(d == 9, "R7 claim", d, 9);
        pulse(9); pulse(9);
        rd(8'h20, d); chk(d[9] == 1'b0, "R5 edge held", d, 0);
        wr(8'h63, 9); rd(8'h20, d); chk(d[9] == 1'b1, "R7 count 1", d, 32'h200);
        rd(8'h63, d); wr(8'h63, 9); rd(8'h20, d); chk(d[9] == 1'b1, "R7 count 2", d, 32'h200);
        rd(8'h63, d); wr(8'h63, 9); rd(8'h20, d); chk(d[9] == 1'b0, "R7 count done", d, 0);

        // R8 absent context
        wr(8'h43, 32'h7FE); wr(8'h66, 0); src[2] = 1'b1; idle(2);
        chk(irq[3] == 1'b0, "R8 irq", 32'(irq), 0);
        rd(8'h67, d); chk(d == 0, "R8 claim", d, 0);

        // random rounds against the bench model
        do_reset();
        prio_m = '0; en_m = '0; thr_m = '0; pend_m = '0;
        for (int it = 0; it < 150; it++) begin
            int c, e;
            src[8:1] = 8'($urandom);
            for (int k = 1; k <= NS; k++) begin
                d = $urandom; wr(8'(k), d); prio_m[k] = d[PW-1:0];
            end
            for (int cc = 0; cc < NC; cc++) begin
                d = $urandom; wr(8'h40 + 8'(cc), d); en_m[cc] = d[NS:1];
                d = $urandom; wr(8'h60 + 8'(2 * cc), d); thr_m[cc] = d[PW-1:0];
            end
            pend_m[8:1] = pend_m[8:1] | src[8:1];
            for (int cc = 0; cc < NC; cc++)
                chk(irq[cc] == (best(cc) != 0), "R3 random irq", 32'(irq), 32'(best(cc)));
            c = int'($urandom % NC);
            e = best(c);
            rd(8'h61 + 8'(2 * c), d);
            chk(d == 32'(e), (PRES[c] ? "R4 random claim" : "R8 random claim"), d, 32'(e));
            if (e != 0) begin
                pend_m[e] = 1'b0;
                wr(8'h61 + 8'(2 * c), 32'(e));
                pend_m[e] = src[e];
            end
            rd(8'h20, d);
            chk(d == 32'({pend_m, 1'b0}), "R6 random pend", d, 32'({pend_m, 1'b0}));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule